// File: doc/BRIEF.md
# Asynchronous Parallel Byte FIFO Port

This block is the device side of an 8-bit parallel port driven by an external controller with no shared clock. The controller pulls a byte out of an internal receive buffer with an active-low read strobe. It pushes a byte into an internal transmit buffer with an active-low write strobe. Two active-low flags pace the controller. The receive-ready flag (`rxf_n_o`) says a byte can be read. The transmit-space flag (`txe_n_o`) says a byte can be written.

Both strobes pass through two-flop synchronisers into the system clock. A strobe counts only once its synchronised level has stayed low for a minimum number of clocks. Each flag is forced inactive while a strobe is in progress and for a fixed recovery time after it ends. After that it returns active only if the buffer condition allows.

On the system side, a valid/ready stream fills the receive buffer and another drains the transmit buffer. Both buffers are small register arrays.

Top module: `pbus_fifo_port`

## Requirements
- R1: `bus_oe_o` is high exactly while `rd_n_i` is low. While it is high, `bus_o` carries the oldest byte in the receive buffer.
- R2: `rxf_n_o` is low only while the receive buffer holds at least one byte and no read strobe is active or recovering.
- R3: A qualified read strobe removes exactly one byte, the oldest one, when the strobe ends. The next read shows the following byte.
- R4: After a qualified read strobe ends, `rxf_n_o` stays high for at least `RECOVER_CLKS` clocks. It then goes low if a byte remains and stays high if the buffer is empty.
- R5: A qualified write strobe stores the byte on `bus_i` into the transmit buffer. Bytes leave on `tx_data_o` in the order they were written.
- R6: Once a write strobe qualifies, `txe_n_o` is high from the next clock. It stays high through the strobe and the recovery time. It returns low only if the transmit buffer is not full.
- R7: A strobe whose synchronised low level lasts fewer than `MIN_PULSE_CLKS` clocks has no effect. No byte is removed or stored, and neither flag changes.
- R8: `rx_ready_o` is low exactly when the receive buffer holds `RX_DEPTH` bytes. A byte offered with `rx_valid_i` while `rx_ready_o` is high is stored.
- R9: A write strobe made while the transmit buffer is full is dropped. The buffered bytes and their order are unchanged.
- R10: `tx_valid_o` is high exactly while the transmit buffer holds a byte. A byte is removed when `tx_valid_o` and `tx_ready_i` are both high at a clock edge.
- R11: After reset both buffers are empty, `rxf_n_o` is high and `bus_oe_o` is low. `txe_n_o` goes low on the first clock after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_n_i | input | 1 | External read strobe, active low, asynchronous |
| wr_n_i | input | 1 | External write strobe, active low, asynchronous |
| bus_i | input | DATA_W | Byte driven by the external controller on the shared bus |
| bus_o | output | DATA_W | Receive byte presented to the shared bus |
| bus_oe_o | output | 1 | Output enable for the shared bus pads |
| rxf_n_o | output | 1 | Active-low flag: a receive byte may be read |
| txe_n_o | output | 1 | Active-low flag: a transmit byte may be written |
| rx_valid_i | input | 1 | System side offers a byte for the receive buffer |
| rx_data_i | input | DATA_W | Byte offered to the receive buffer |
| rx_ready_o | output | 1 | Receive buffer can accept a byte |
| tx_valid_o | output | 1 | Transmit buffer holds a byte |
| tx_data_o | output | DATA_W | Oldest byte in the transmit buffer |
| tx_ready_i | input | 1 | System side takes the byte on tx_data_o |

## Verification
Directed cases cover several situations. Single-clock and one-short-of-minimum strobes tell the glitch filter apart from real accesses. Back-to-back reads with a second byte pending tell the recovery window apart from a flag that returns at once. Reads that empty the buffer show the flag must stay inactive. Filling either buffer to depth and then pushing once more separates the full case from ordinary flow. A seeded random mix of system pushes, external reads, external writes and drains interleaves the two directions. This exposes ordering faults and any cross-coupling between the receive and transmit paths.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

  // Qualified strobe events in the system clock domain.
  typedef struct packed {
    logic act;    // strobe qualified and still low
    logic start;  // one-cycle pulse when the strobe qualifies
    logic done;   // one-cycle pulse when a qualified strobe ends
  } strobe_ev_t;

endpackage

// File: rtl/pbus_strobe_qual.sv
module pbus_strobe_qual #(
  parameter int MIN_PULSE = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   strb_n_i,
  output pbus_pkg::strobe_ev_t   ev_o
);
  localparam int CW = $clog2(MIN_PULSE + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] lo_cnt_q;
  logic          act_q;
  logic          lvl_low;
  logic          start_w;
  logic          done_w;

  function automatic logic [CW-1:0] cnt_next(input logic [CW-1:0] c, input logic low);
    if (!low)                   return '0;
    else if (c == CW'(MIN_PULSE)) return c;
    else                        return c + 1'b1;
  endfunction

  assign lvl_low = ~sync_q[1];
  assign start_w = lvl_low && !act_q && (lo_cnt_q == CW'(MIN_PULSE - 1));
  assign done_w  = act_q && !lvl_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= 2'b11;
      lo_cnt_q <= '0;
      act_q    <= 1'b0;
    end else begin
      sync_q   <= {sync_q[0], strb_n_i};
      lo_cnt_q <= cnt_next(lo_cnt_q, lvl_low);
      if (start_w)       act_q <= 1'b1;
      else if (!lvl_low) act_q <= 1'b0;
    end
  end

  assign ev_o.act   = act_q;
  assign ev_o.start = start_w;
  assign ev_o.done  = done_w;

  assert_start_sets_act_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start_w |=> act_q);
  assert_done_clears_act_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_w |=> !act_q);
endmodule

// File: rtl/pbus_byte_fifo.sv
module pbus_byte_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic [W-1:0] push_data_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);

  logic [W-1:0]    mem_q [DEPTH];
  logic [AW-1:0]   wr_ptr_q;
  logic [AW-1:0]   rd_ptr_q;
  logic [CNTW-1:0] cnt_q;

  function automatic logic [AW-1:0] ptr_step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [CNTW-1:0] fill_next(input logic [CNTW-1:0] c,
                                                input logic push, input logic pop);
    return c + CNTW'(push) - CNTW'(pop);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= ptr_step(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= ptr_step(rd_ptr_q);
      cnt_q <= fill_next(cnt_q, push_i, pop_i);
    end
  end

  always_ff @(posedge clk) begin
    if (push_i) mem_q[wr_ptr_q] <= push_data_i;
  end

  assign head_o  = mem_q[rd_ptr_q];
  assign full_o  = (cnt_q == CNTW'(DEPTH));
  assign empty_o = (cnt_q == '0);

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    full_o |-> !push_i);
  assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    empty_o |-> !pop_i);
endmodule

// File: rtl/pbus_flag_ctl.sv
module pbus_flag_ctl #(
  parameter int RECOVER_CLKS = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  pbus_pkg::strobe_ev_t ev_i,
  input  logic                 allow_i,
  output logic                 flag_n_o
);
  localparam int RW = $clog2(RECOVER_CLKS + 2);

  logic [RW-1:0] rec_q;
  logic          flag_n_q;
  logic          busy_w;

  function automatic logic [RW-1:0] rec_next(input logic [RW-1:0] r, input logic load);
    if (load)         return RW'(RECOVER_CLKS);
    else if (r != '0) return r - 1'b1;
    else              return r;
  endfunction

  assign busy_w = ev_i.act | ev_i.start | (rec_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_q    <= '0;
      flag_n_q <= 1'b1;
    end else begin
      rec_q    <= rec_next(rec_q, ev_i.done);
      flag_n_q <= busy_w | ~allow_i;
    end
  end

  assign flag_n_o = flag_n_q;

  assert_flag_off_in_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_i.start || ev_i.act) |=> flag_n_q);
  assert_flag_off_after_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_i.done |=> (flag_n_q && rec_q != '0));
endmodule

// File: rtl/pbus_fifo_port.sv
module pbus_fifo_port #(
  parameter int DATA_W         = 8,
  parameter int RX_DEPTH       = 4,
  parameter int TX_DEPTH       = 4,
  parameter int MIN_PULSE_CLKS = 3,
  parameter int RECOVER_CLKS   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_n_i,
  input  logic              wr_n_i,
  input  logic [DATA_W-1:0] bus_i,
  output logic [DATA_W-1:0] bus_o,
  output logic              bus_oe_o,
  output logic              rxf_n_o,
  output logic              txe_n_o,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  output logic              rx_ready_o,
  output logic              tx_valid_o,
  output logic [DATA_W-1:0] tx_data_o,
  input  logic              tx_ready_i
);
  pbus_pkg::strobe_ev_t rd_ev;
  pbus_pkg::strobe_ev_t wr_ev;

  logic              rx_push, rx_pop, rx_full, rx_empty;
  logic              tx_push, tx_pop, tx_full, tx_empty;
  logic [DATA_W-1:0] rx_head, tx_head;

  pbus_strobe_qual #(.MIN_PULSE(MIN_PULSE_CLKS)) u_rd_qual (
    .clk(clk), .rst_n(rst_n), .strb_n_i(rd_n_i), .ev_o(rd_ev));
  pbus_strobe_qual #(.MIN_PULSE(MIN_PULSE_CLKS)) u_wr_qual (
    .clk(clk), .rst_n(rst_n), .strb_n_i(wr_n_i), .ev_o(wr_ev));

  // Receive path: system stream in, external reads out.
  assign rx_push = rx_valid_i && !rx_full;
  assign rx_pop  = rd_ev.done && !rx_empty;

  pbus_byte_fifo #(.W(DATA_W), .DEPTH(RX_DEPTH)) u_rx_buf (
    .clk(clk), .rst_n(rst_n),
    .push_i(rx_push), .push_data_i(rx_data_i), .pop_i(rx_pop),
    .head_o(rx_head), .full_o(rx_full), .empty_o(rx_empty));

  // Transmit path: external writes in, system stream out.
  assign tx_push = wr_ev.start && !tx_full;
  assign tx_pop  = tx_valid_o && tx_ready_i;

  pbus_byte_fifo #(.W(DATA_W), .DEPTH(TX_DEPTH)) u_tx_buf (
    .clk(clk), .rst_n(rst_n),
    .push_i(tx_push), .push_data_i(bus_i), .pop_i(tx_pop),
    .head_o(tx_head), .full_o(tx_full), .empty_o(tx_empty));

  pbus_flag_ctl #(.RECOVER_CLKS(RECOVER_CLKS)) u_rxf_ctl (
    .clk(clk), .rst_n(rst_n), .ev_i(rd_ev), .allow_i(!rx_empty), .flag_n_o(rxf_n_o));
  pbus_flag_ctl #(.RECOVER_CLKS(RECOVER_CLKS)) u_txe_ctl (
    .clk(clk), .rst_n(rst_n), .ev_i(wr_ev), .allow_i(!tx_full), .flag_n_o(txe_n_o));

  assign bus_oe_o   = ~rd_n_i;
  assign bus_o      = rx_head;
  assign rx_ready_o = !rx_full;
  assign tx_valid_o = !tx_empty;
  assign tx_data_o  = tx_head;

  assert_rxf_needs_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rxf_n_o |-> !rx_empty);
  assert_txe_needs_space_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !txe_n_o |-> !tx_full);
  assert_txe_off_on_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ev.start |=> txe_n_o);
  assert_rxf_off_on_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ev.done |=> rxf_n_o);
endmodule

// File: tb/test_pbus_fifo_port.sv
module test_pbus_fifo_port;
  localparam int CLK_PERIOD = 10;
  localparam int DW   = 8;
  localparam int RXD  = 4;
  localparam int TXD  = 4;
  localparam int MINP = 3;
  localparam int REC  = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_n = 1'b1, wr_n = 1'b1;
  logic [DW-1:0] bus_i = '0;
  logic [DW-1:0] bus_o;
  logic bus_oe, rxf_n, txe_n;
  logic rx_valid = 1'b0;
  logic [DW-1:0] rx_data = '0;
  logic rx_ready, tx_valid;
  logic [DW-1:0] tx_data;
  logic tx_ready = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [DW-1:0] rx_model[$];
  logic [DW-1:0] tx_model[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pbus_fifo_port #(.DATA_W(DW), .RX_DEPTH(RXD), .TX_DEPTH(TXD),
                   .MIN_PULSE_CLKS(MINP), .RECOVER_CLKS(REC)) i_pbus_fifo_port (
    .clk(clk), .rst_n(rst_n), .rd_n_i(rd_n), .wr_n_i(wr_n),
    .bus_i(bus_i), .bus_o(bus_o), .bus_oe_o(bus_oe),
    .rxf_n_o(rxf_n), .txe_n_o(txe_n),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_ready_o(rx_ready),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_ready_i(tx_ready));

  // Longest expected gap from the end of a read to rxf_n returning low.
  function automatic int gap_max();
    return REC + 6;
  endfunction

  function automatic bit exp_accept(input int fill, input int depth);
    return fill < depth;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_low(ref logic sig, output int cyc);
    cyc = 0;
    while (sig && cyc < 200) begin tick(1); cyc++; end
  endtask

  task automatic rx_push(input logic [DW-1:0] b);
    bit exp;
    exp = exp_accept(rx_model.size(), RXD);
    rx_valid = 1'b1; rx_data = b;
    check(rx_ready == exp, "R8 rx_ready", int'(rx_ready), int'(exp));
    tick(1);
    rx_valid = 1'b0;
    if (exp) rx_model.push_back(b);
  endtask

  task automatic ext_read();
    logic [DW-1:0] want;
    want = rx_model[0];
    rd_n = 1'b0;
    tick(2);
    check(bus_oe == 1'b1, "R1 bus_oe low strobe", int'(bus_oe), 1);
    check(bus_o == want, "R1 R3 bus byte", int'(bus_o), int'(want));
    tick(4);
    rd_n = 1'b1;
    tick(1);
    check(bus_oe == 1'b0, "R1 bus_oe released", int'(bus_oe), 0);
    void'(rx_model.pop_front());
  endtask

  task automatic ext_write(input logic [DW-1:0] b);
    bit room;
    room = exp_accept(tx_model.size(), TXD);
    bus_i = b;
    wr_n = 1'b0;
    tick(6);
    check(txe_n == 1'b1, "R6 txe_n high in strobe", int'(txe_n), 1);
    wr_n = 1'b1;
    tick(3);
    if (room) tx_model.push_back(b);
  endtask

  task automatic drain_one();
    int c;
    c = 0;
    while (!tx_valid && c < 10) begin tick(1); c++; end
    if (tx_model.size() == 0) begin
      check(tx_valid == 1'b0, "R10 tx_valid empty", int'(tx_valid), 0);
    end else begin
      check(tx_valid == 1'b1, "R10 tx_valid", int'(tx_valid), 1);
      check(tx_data == tx_model[0], "R5 tx order", int'(tx_data), int'(tx_model[0]));
      tx_ready = 1'b1;
      tick(1);
      tx_ready = 1'b0;
      void'(tx_model.pop_front());
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int gap;
    int unsigned seed;
    seed = $urandom(32'h1f2e3d4c);
    tick(3);
    rst_n = 1'b1;
    tick(3);
    // R11 reset state
    check(rxf_n == 1'b1, "R11 rxf_n", int'(rxf_n), 1);
    check(txe_n == 1'b0, "R11 txe_n", int'(txe_n), 0);
    check(bus_oe == 1'b0, "R11 bus_oe", int'(bus_oe), 0);
    check(tx_valid == 1'b0, "R11 tx_valid", int'(tx_valid), 0);
    check(rx_ready == 1'b1, "R11 rx_ready", int'(rx_ready), 1);

    // R2 R3 R4: two bytes, read one, measure recovery
    rx_push(8'h11);
    rx_push(8'h22);
    wait_low(rxf_n, gap);
    check(rxf_n == 1'b0, "R2 rxf_n with data", int'(rxf_n), 0);
    ext_read();
    gap = 1;
    while (rxf_n && gap < 200) begin tick(1); gap++; end
    check(gap >= REC && gap <= gap_max(), "R4 recovery gap", gap, REC);

    // R7: short read pulses have no effect
    rd_n = 1'b0; tick(1); rd_n = 1'b1; tick(REC + 8);
    check(rxf_n == 1'b0, "R7 rxf_n after 1-clk glitch", int'(rxf_n), 0);
    rd_n = 1'b0; tick(MINP - 1); rd_n = 1'b1; tick(REC + 8);
    check(rxf_n == 1'b0, "R7 rxf_n after short pulse", int'(rxf_n), 0);
    ext_read();  // must still show 0x22 (R3, R7)
    tick(3 * REC);
    check(rxf_n == 1'b1, "R4 rxf_n stays high when empty", int'(rxf_n), 1);

    // R8: fill RX past depth
    for (int i = 0; i < RXD + 1; i++) rx_push(8'h40 + 8'(i));
    check(rx_ready == 1'b0, "R8 rx_ready full", int'(rx_ready), 0);
    while (rx_model.size() > 0) begin
      wait_low(rxf_n, gap);
      ext_read();
    end

    // R7: short write pulse is ignored
    bus_i = 8'hA5; wr_n = 1'b0; tick(MINP - 1); wr_n = 1'b1; tick(REC + 8);
    check(tx_valid == 1'b0, "R7 no byte from short write", int'(tx_valid), 0);
    check(txe_n == 1'b0, "R7 txe_n unchanged", int'(txe_n), 0);

    // R5 R6 R9: fill TX, then write into a full buffer
    for (int i = 0; i < TXD; i++) begin
      wait_low(txe_n, gap);
      check(txe_n == 1'b0, "R6 txe_n with space", int'(txe_n), 0);
      ext_write(8'hC0 + 8'(i));
    end
    tick(REC + 8);
    check(txe_n == 1'b1, "R6 txe_n high when full", int'(txe_n), 1);
    ext_write(8'hEE);
    for (int i = 0; i < TXD; i++) drain_one();
    tick(2);
    check(tx_valid == 1'b0, "R9 dropped byte absent", int'(tx_valid), 0);
    tick(REC + 8);
    check(txe_n == 1'b0, "R6 txe_n back low", int'(txe_n), 0);

    // Random mix
    for (int it = 0; it < 80; it++) begin
      int op;
      op = int'($urandom_range(3, 0));
      case (op)
        0: rx_push(8'($urandom));
        1: begin
          if (rx_model.size() > 0) begin
            wait_low(rxf_n, gap);
            check(rxf_n == 1'b0, "R2 rxf_n random", int'(rxf_n), 0);
            ext_read();
          end else begin
            tick(REC + 8);
            check(rxf_n == 1'b1, "R2 rxf_n empty", int'(rxf_n), 1);
          end
        end
        2: begin
          if (tx_model.size() < TXD) begin
            wait_low(txe_n, gap);
            check(txe_n == 1'b0, "R6 txe_n random", int'(txe_n), 0);
          end else begin
            tick(REC + 8);
            check(txe_n == 1'b1, "R9 txe_n full", int'(txe_n), 1);
          end
          ext_write(8'($urandom));
        end
        default: drain_one();
      endcase
    end
    while (tx_model.size() > 0) drain_one();
    drain_one();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule